// File: doc/BRIEF.md
# Indexed Register Host Port for a Display Controller

This block sits between a 16-bit host bus and the configuration state of a display controller. The host reaches an 8-bit register space through one index/data pair. A strobe with the data/command flag low loads a register index. A strobe with the flag high reads or writes the register that the index selects. After a data access the index moves on by itself, so a host can stream a run of registers without reloading it.

The port holds the register file itself. This includes:
- coordinate registers split into a low byte and a high part,
- control registers that keep only their defined bits,
- two read-only identification constants,
- two auto-incrementing lookup tables: a 256-entry wrap-around colour-correction table and a 32-entry coefficient table that stops at its end,
- an interrupt status byte that hardware events set and host writes clear.

A host-loadable drop counter makes the port ignore a given number of accesses. Read data appears one cycle after the read strobe, from registers and from block RAM.

Top module: `dispctl_regport`

## Requirements
- R1: A write strobe with `dc` low loads `wdata[7:0]` as the register index and changes no register.
- R2: A write strobe with `dc` high writes the indexed register, then adds 2 to the index. At the three streaming ports 0x90 (pixel data), 0x5a (coefficient data) and 0xb8 (colour table data) the index stays put.
- R3: A read strobe with `dc` high adds 1 to the index after the read. A read with `dc` low leaves the index unchanged.
- R4: `drop_set` loads the drop counter from `drop_num`. While the counter is non-zero, each strobe decrements it and is ignored: no register or index changes, and a read returns 0.
- R5: Address 0x00 reads 0x00a5 and address 0x02 reads 0x0083. Writes to them have no effect.
- R6: There are eight 10-bit coordinates. Coordinate k has its low register at 0x6c+4k and its high register at 0x6e+4k. The low register sets bits 7:0 and keeps bits 9:8. The high register sets bits 9:8 from `wdata[1:0]` and keeps bits 7:0. The high register reads back bits 9:8 in `rdata[1:0]`.
- R7: The colour table index lives at 0xb6. Each read or write at 0xb8 accesses entry[index] and then increments the index modulo 256.
- R8: The coefficient index lives at 0x58 and is written from `wdata[4:0]`. Each access at 0x5a increments it while it is below 32. At index 32 a read returns 0, a write is dropped, and the index holds. 0x58 reads back the full index, up to 0x20.
- R9: Interrupt status lives at 0xf6. Each bit of `gpio_evt` sets its status bit. A write ANDs `wdata[7:0]` into the status. If an event and a clearing write fall in the same cycle, the event bit stays set.
- R10: The PLL divider at 0x04 stores `wdata[5:0]+1` and reads back (stored−1) with bit 7 set. The panel width at 0x2a stores `wdata[7:0]*8` and reads back the width divided by 8.
- R11: The reset values read back as follows: 0x8c=0x03, 0xe6=0x02, 0xf8=0xff, 0x18=0x5c, 0x1a=0x02, 0x28=0x74, 0x04=0x88, 0x2a=0x01.
- R12: An access to an undecoded address reads 0 and ignores writes. It raises `err` for exactly the cycle after the strobe.
- R13: The writable bit masks are:
  - 0xe6 keeps bits 7, 1 and 0.
  - 0x8c keeps bits 3:0.
  - 0x1a supplies refresh bits 11:8 from `wdata[3:0]`.
  - 0x18 supplies refresh bits 7:0.
- R14: `rvalid` is high exactly in the cycle after an accepted-or-dropped read strobe. `rdata` holds that read's value, with bits 15:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One access per cycle while high |
| we | input | 1 | 1 = write, 0 = read |
| dc | input | 1 | Data/command flag: 0 = index, 1 = data |
| wdata | input | 16 | Write value |
| drop_set | input | 1 | Load the drop counter (a strobe in the same cycle is lost) |
| drop_num | input | 4 | Number of accesses to ignore |
| gpio_evt | input | 8 | Per-bit interrupt event pulses |
| rdata | output | 16 | Read value, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| err | output | 1 | Access to an undecoded address |

## Verification
Two functions can hit the interrupt status byte in the same clock: a hardware event that sets a bit, and a host write that clears bits. The bench provokes this by holding `gpio_evt` high during the very strobe that writes zero to 0xf6. It then reads the byte back through the data port and expects the event bit to survive while every other bit is cleared. A second collision involves the drop counter running down while the index register would otherwise be stepping. The bench checks this by reading the index's target after a dropped write and a dropped read. Both reads must show that neither the index nor any register moved.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam logic [7:0] A_REV  = 8'h00;
  localparam logic [7:0] A_CFG  = 8'h02;
  localparam logic [7:0] A_PLL  = 8'h04;
  localparam logic [7:0] A_RFL  = 8'h18;
  localparam logic [7:0] A_RFH  = 8'h1a;
  localparam logic [7:0] A_LCD  = 8'h28;
  localparam logic [7:0] A_WID  = 8'h2a;
  localparam logic [7:0] A_FIDX = 8'h58;
  localparam logic [7:0] A_FDAT = 8'h5a;
  localparam logic [7:0] A_WIN0 = 8'h6c;
  localparam logic [7:0] A_FMT  = 8'h8c;
  localparam logic [7:0] A_PIX  = 8'h90;
  localparam logic [7:0] A_GIDX = 8'hb6;
  localparam logic [7:0] A_GDAT = 8'hb8;
  localparam logic [7:0] A_PWR  = 8'he6;
  localparam logic [7:0] A_IRQ  = 8'hf6;
  localparam logic [7:0] A_PDN  = 8'hf8;

  localparam logic [7:0] REV_CODE = 8'ha5;
  localparam logic [7:0] CFG_CODE = 8'h83;

  typedef enum logic [1:0] {PK_REG, PK_GAM, PK_FIL} pick_t;
endpackage

// File: rtl/rp_cursor.sv
module rp_cursor #(
  parameter int AW    = 8,
  parameter int DROPW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             we,
  input  logic             dc,
  input  logic [AW-1:0]    wlow,
  input  logic             drop_set,
  input  logic [DROPW-1:0] drop_num,
  output logic [AW-1:0]    idx,
  output logic             live
);
  import rp_pkg::*;

  logic [DROPW-1:0] cnt;
  logic             stream;

  assign stream = (idx == AW'(A_PIX)) || (idx == AW'(A_FDAT)) || (idx == AW'(A_GDAT));
  assign live   = strobe && !drop_set && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      cnt <= '0;
    end else if (drop_set) begin
      cnt <= drop_num;
    end else if (strobe) begin
      if (cnt != '0)
        cnt <= cnt - 1'b1;
      else if (!dc) begin
        if (we) idx <= wlow;
      end else if (we) begin
        if (!stream) idx <= idx + AW'(2);
      end else begin
        idx <= idx + AW'(1);
      end
    end
  end

  assert_hold_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe && !drop_set && cnt != '0) |=> (idx == $past(idx)) && (cnt == $past(cnt) - 1'b1));

  assert_step_two_R2: assert property (@(posedge clk) disable iff (rst)
    (live && dc && we && !stream) |=> idx == $past(idx) + AW'(2));

  assert_stream_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (live && dc && we && stream) |=> idx == $past(idx));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (live && dc && !we) |=> idx == $past(idx) + AW'(1));
endmodule

// File: rtl/rp_table.sv
module rp_table #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter bit WRAP  = 1'b1,
  localparam int AB   = $clog2(DEPTH),
  localparam int IW   = AB + (WRAP ? 0 : 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_idx,
  input  logic [AB-1:0] set_val,
  input  logic          acc,
  input  logic          acc_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [IW-1:0] idx_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic          zero_q;
  logic [IW-1:0] idx;
  logic          in_rng;

  generate
    if (WRAP) begin : g_wrap
      assign in_rng = 1'b1;
    end else begin : g_stop
      assign in_rng = ~idx[IW-1];
      assert_table_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && !in_rng && !set_idx) |=> idx == $past(idx));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (acc && acc_we && in_rng) mem[idx[AB-1:0]] <= wdata;
    if (acc) mem_q <= mem[idx[AB-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      zero_q <= 1'b0;
    end else begin
      if (acc) zero_q <= !in_rng;
      if (set_idx) idx <= IW'(set_val);
      else if (acc && in_rng) idx <= idx + 1'b1;
    end
  end

  assign rdata = zero_q ? '0 : mem_q;
  assign idx_o = idx;

  // Stepping after an in-range access serves both R7 and R8.
  assert_table_step_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && in_rng && !set_idx) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/dispctl_regport.sv
module dispctl_regport #(
  parameter int DW     = 16,
  parameter int AW     = 8,
  parameter int DROPW  = 4,
  parameter int NCOORD = 8,
  parameter int CW     = 10,
  parameter int GDEPTH = 256,
  parameter int FDEPTH = 32,
  localparam int GAB   = $clog2(GDEPTH),
  localparam int FAB   = $clog2(FDEPTH),
  localparam int FIW   = FAB + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             we,
  input  logic             dc,
  input  logic [DW-1:0]    wdata,
  input  logic             drop_set,
  input  logic [DROPW-1:0] drop_num,
  input  logic [7:0]       gpio_evt,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             err
);
  import rp_pkg::*;

  logic [AW-1:0] idx;
  logic          live, wr, rd;
  logic          unused_hi;

  assign wr = live && dc && we;
  assign rd = live && !we;
  assign unused_hi = ^wdata[DW-1:8];

  rp_cursor #(.AW(AW), .DROPW(DROPW)) u_cur (
    .clk(clk), .rst(rst), .strobe(strobe), .we(we), .dc(dc),
    .wlow(wdata[AW-1:0]), .drop_set(drop_set), .drop_num(drop_num),
    .idx(idx), .live(live)
  );

  logic [7:0]     g_rd;
  logic [GAB-1:0] g_idx;
  logic [7:0]     f_rd;
  logic [FIW-1:0] f_idx;

  rp_table #(.DEPTH(GDEPTH), .DW(8), .WRAP(1'b1)) u_gam (
    .clk(clk), .rst(rst),
    .set_idx(wr && idx == AW'(A_GIDX)), .set_val(wdata[GAB-1:0]),
    .acc((wr || rd) && idx == AW'(A_GDAT)), .acc_we(we),
    .wdata(wdata[7:0]), .rdata(g_rd), .idx_o(g_idx)
  );

  rp_table #(.DEPTH(FDEPTH), .DW(8), .WRAP(1'b0)) u_fil (
    .clk(clk), .rst(rst),
    .set_idx(wr && idx == AW'(A_FIDX)), .set_val(wdata[FAB-1:0]),
    .acc((wr || rd) && idx == AW'(A_FDAT)), .acc_we(we),
    .wdata(wdata[7:0]), .rdata(f_rd), .idx_o(f_idx)
  );

  // Register file
  logic [6:0]    pll;
  logic [11:0]   rfsh;
  logic [7:0]    lcd;
  logic [10:0]   wid;
  logic [3:0]    fmt;
  logic [7:0]    pwr;
  logic [7:0]    irq;
  logic [7:0]    pdn;
  logic [CW-1:0] coord [NCOORD];

  always_ff @(posedge clk) begin
    if (rst) begin
      pll  <= 7'd9;
      rfsh <= 12'h25c;
      lcd  <= 8'h74;
      wid  <= 11'd8;
      fmt  <= 4'd3;
      pwr  <= 8'h02;
      irq  <= 8'h00;
      pdn  <= 8'hff;
      for (int i = 0; i < NCOORD; i++) coord[i] <= '0;
    end else begin
      if (wr) begin
        case (idx)
          AW'(A_PLL): pll <= {1'b0, wdata[5:0]} + 7'd1;
          AW'(A_RFL): rfsh[7:0] <= wdata[7:0];
          AW'(A_RFH): rfsh[11:8] <= wdata[3:0];
          AW'(A_LCD): lcd <= wdata[7:0];
          AW'(A_WID): wid <= {wdata[7:0], 3'b000};
          AW'(A_FMT): fmt <= wdata[3:0];
          AW'(A_PWR): pwr <= wdata[7:0] & 8'h83;
          AW'(A_PDN): pdn <= wdata[7:0];
          default: ;
        endcase
        for (int i = 0; i < NCOORD; i++) begin
          if (idx == AW'(int'(A_WIN0) + 4 * i))
            coord[i][7:0] <= wdata[7:0];
          if (idx == AW'(int'(A_WIN0) + 4 * i + 2))
            coord[i][CW-1:8] <= wdata[CW-9:0];
        end
      end
      irq <= ((wr && idx == AW'(A_IRQ)) ? (irq & wdata[7:0]) : irq) | gpio_evt;
    end
  end

  // Read decode
  logic [7:0] rv;
  logic       known;
  pick_t      pick_c;

  always_comb begin
    rv     = '0;
    known  = 1'b1;
    pick_c = PK_REG;
    case (idx)
      AW'(A_REV):  rv = REV_CODE;
      AW'(A_CFG):  rv = CFG_CODE;
      AW'(A_PLL):  rv = 8'h80 | {1'b0, pll - 7'd1};
      AW'(A_RFL):  rv = rfsh[7:0];
      AW'(A_RFH):  rv = {4'b0, rfsh[11:8]};
      AW'(A_LCD):  rv = lcd;
      AW'(A_WID):  rv = wid[10:3];
      AW'(A_FIDX): rv = 8'(f_idx);
      AW'(A_FDAT): pick_c = PK_FIL;
      AW'(A_FMT):  rv = {4'b0, fmt};
      AW'(A_PIX):  rv = '0;
      AW'(A_GIDX): rv = 8'(g_idx);
      AW'(A_GDAT): pick_c = PK_GAM;
      AW'(A_PWR):  rv = pwr;
      AW'(A_IRQ):  rv = irq;
      AW'(A_PDN):  rv = pdn;
      default:     known = 1'b0;
    endcase
    for (int i = 0; i < NCOORD; i++) begin
      if (idx == AW'(int'(A_WIN0) + 4 * i)) begin
        known = 1'b1;
        rv    = coord[i][7:0];
      end
      if (idx == AW'(int'(A_WIN0) + 4 * i + 2)) begin
        known = 1'b1;
        rv    = 8'(coord[i][CW-1:8]);
      end
    end
  end

  logic [7:0] rd_q;
  pick_t      pick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
      rd_q   <= '0;
      pick_q <= PK_REG;
    end else begin
      rvalid <= strobe && !we && !drop_set;
      err    <= live && (dc || !we) && !known;
      if (strobe && !we) begin
        rd_q   <= rd ? rv : 8'h00;
        pick_q <= rd ? pick_c : PK_REG;
      end
    end
  end

  always_comb begin
    case (pick_q)
      PK_GAM:  rdata = DW'(g_rd);
      PK_FIL:  rdata = DW'(f_rd);
      default: rdata = DW'(rd_q);
    endcase
  end

  assert_rev_const_R5: assert property (@(posedge clk) disable iff (rst)
    (rvalid && $past(rd) && $past(idx) == AW'(A_REV)) |-> rdata == DW'(REV_CODE));

  assert_err_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (err && rvalid) |-> rdata == '0);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(wr && idx == AW'(A_IRQ) && gpio_evt == 8'h00) |-> (irq & ~$past(wdata[7:0])) == 8'h00);

  assert_rvalid_timing_R14: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(strobe && !we));
endmodule

// File: tb/dispctl_regport_test.sv
module dispctl_regport_test;
  localparam int CLK_P = 10;
  localparam int NV    = 90;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0, we = 1'b0, dc = 1'b0;
  logic [15:0] wdata = '0;
  logic        drop_set = 1'b0;
  logic [3:0]  drop_num = '0;
  logic [7:0]  gpio_evt = '0;
  logic [15:0] rdata;
  logic        rvalid, err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dispctl_regport uut (
    .clk(clk), .rst(rst), .strobe(strobe), .we(we), .dc(dc), .wdata(wdata),
    .drop_set(drop_set), .drop_num(drop_num), .gpio_evt(gpio_evt),
    .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  // {we, dc, wdata, expected read byte, requirement (0 = no check)}
  localparam logic [29:0] VEC [NV] = '{
    {2'b10, 16'h008c, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h03, 4'd11}, // R11
    {2'b10, 16'h00e6, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h02, 4'd11},
    {2'b10, 16'h00f8, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'hff, 4'd11},
    {2'b10, 16'h0018, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h5c, 4'd11},
    {2'b10, 16'h001a, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h02, 4'd11},
    {2'b10, 16'h0028, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h74, 4'd11},
    {2'b10, 16'h0004, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h88, 4'd11},
    {2'b10, 16'h002a, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h01, 4'd11},
    // R1 index load, R5 constants, R3 read step of one
    {2'b10, 16'h0000, 8'h00, 4'd0}, {2'b01, 16'h0000, 8'ha5, 4'd5},
    {2'b01, 16'h0000, 8'h00, 4'd3}, {2'b01, 16'h0000, 8'h83, 4'd3},
    {2'b10, 16'h0000, 8'h00, 4'd0}, {2'b11, 16'h0077, 8'h00, 4'd0},
    {2'b10, 16'h0000, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'ha5, 4'd5},
    // R6 split coordinates, R2 write step of two
    {2'b10, 16'h006c, 8'h00, 4'd0}, {2'b11, 16'h01ab, 8'h00, 4'd0},
    {2'b11, 16'h0003, 8'h00, 4'd0}, {2'b11, 16'h0007, 8'h00, 4'd0},
    {2'b10, 16'h006c, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'hab, 4'd6},
    {2'b10, 16'h006e, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h03, 4'd6},
    {2'b10, 16'h006c, 8'h00, 4'd0}, {2'b11, 16'h0055, 8'h00, 4'd0},
    {2'b10, 16'h006e, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h03, 4'd6},
    {2'b10, 16'h0070, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h07, 4'd2},
    // R7 colour table wrap, streaming port holds index
    {2'b10, 16'h00b6, 8'h00, 4'd0}, {2'b11, 16'h00fe, 8'h00, 4'd0},
    {2'b11, 16'h0011, 8'h00, 4'd0}, {2'b11, 16'h0022, 8'h00, 4'd0},
    {2'b11, 16'h0033, 8'h00, 4'd0}, {2'b10, 16'h00b6, 8'h00, 4'd0},
    {2'b11, 16'h00fe, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h11, 4'd7},
    {2'b00, 16'h0000, 8'h22, 4'd7}, {2'b00, 16'h0000, 8'h33, 4'd7},
    {2'b10, 16'h00b6, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h01, 4'd7},
    // R8 coefficient table stops at 32
    {2'b10, 16'h0058, 8'h00, 4'd0}, {2'b11, 16'h001e, 8'h00, 4'd0},
    {2'b11, 16'h00a1, 8'h00, 4'd0}, {2'b11, 16'h00a2, 8'h00, 4'd0},
    {2'b11, 16'h00a3, 8'h00, 4'd0}, {2'b10, 16'h0058, 8'h00, 4'd0},
    {2'b00, 16'h0000, 8'h20, 4'd8}, {2'b11, 16'h003e, 8'h00, 4'd0},
    {2'b00, 16'h0000, 8'ha1, 4'd8}, {2'b00, 16'h0000, 8'ha2, 4'd8},
    {2'b00, 16'h0000, 8'h00, 4'd8}, {2'b00, 16'h0000, 8'h00, 4'd8},
    // R13 masks
    {2'b10, 16'h00e6, 8'h00, 4'd0}, {2'b11, 16'h00ff, 8'h00, 4'd0},
    {2'b10, 16'h00e6, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h83, 4'd13},
    {2'b10, 16'h008c, 8'h00, 4'd0}, {2'b11, 16'h00f7, 8'h00, 4'd0},
    {2'b10, 16'h008c, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h07, 4'd13},
    {2'b10, 16'h0018, 8'h00, 4'd0}, {2'b11, 16'h0034, 8'h00, 4'd0},
    {2'b11, 16'h00fe, 8'h00, 4'd0}, {2'b10, 16'h0018, 8'h00, 4'd0},
    {2'b00, 16'h0000, 8'h34, 4'd13}, {2'b10, 16'h001a, 8'h00, 4'd0},
    {2'b00, 16'h0000, 8'h0e, 4'd13},
    // R10 scaled registers
    {2'b10, 16'h002a, 8'h00, 4'd0}, {2'b11, 16'h0050, 8'h00, 4'd0},
    {2'b10, 16'h002a, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h50, 4'd10},
    {2'b10, 16'h0004, 8'h00, 4'd0}, {2'b11, 16'h00c5, 8'h00, 4'd0},
    {2'b10, 16'h0004, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h85, 4'd10},
    // R12 undecoded address
    {2'b10, 16'h0003, 8'h00, 4'd0}, {2'b00, 16'h0000, 8'h00, 4'd12},
    {2'b11, 16'h00ff, 8'h00, 4'd0}, {2'b10, 16'h0003, 8'h00, 4'd0},
    {2'b00, 16'h0000, 8'h00, 4'd12}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic w, input logic d, input logic [15:0] v);
    @(negedge clk);
    we = w; dc = d; wdata = v; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14 reset rvalid", {15'b0, rvalid}, 16'h0);
    chk("R12 reset err", {15'b0, err}, 16'h0);
    chk("R11 reset rdata", rdata, 16'h0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][29], VEC[i][28], VEC[i][27:12]);
      if (VEC[i][3:0] != 4'd0)
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), rdata, {8'h00, VEC[i][11:4]});
    end

    // R14: rvalid for one cycle after a read, never after a write
    acc(1'b1, 1'b0, 16'h0000);
    chk("R14 no rvalid on write", {15'b0, rvalid}, 16'h0);
    chk("R1 index load no err", {15'b0, err}, 16'h0);
    acc(1'b0, 1'b0, 16'h0000);
    chk("R14 rvalid after read", {15'b0, rvalid}, 16'h1);
    chk("R14 read data", rdata, 16'h00a5);
    @(negedge clk);
    chk("R14 rvalid drops", {15'b0, rvalid}, 16'h0);

    // R12: err pulse
    acc(1'b1, 1'b0, 16'h0003);
    acc(1'b0, 1'b0, 16'h0000);
    chk("R12 err raised", {15'b0, err}, 16'h1);
    @(negedge clk);
    chk("R12 err one cycle", {15'b0, err}, 16'h0);

    // R4: dropped accesses
    acc(1'b1, 1'b0, 16'h0002);
    @(negedge clk); drop_set = 1'b1; drop_num = 4'd2;
    @(negedge clk); drop_set = 1'b0;
    acc(1'b1, 1'b0, 16'h0000);
    acc(1'b0, 1'b1, 16'h0000);
    chk("R4 dropped read is zero", rdata, 16'h0000);
    chk("R4 dropped read rvalid", {15'b0, rvalid}, 16'h1);
    acc(1'b0, 1'b0, 16'h0000);
    chk("R4 index unchanged", rdata, 16'h0083);

    // R9: interrupt status
    @(negedge clk); gpio_evt = 8'h0f;
    @(negedge clk); gpio_evt = 8'h00;
    acc(1'b1, 1'b0, 16'h00f6);
    acc(1'b0, 1'b0, 16'h0000);
    chk("R9 events set", rdata, 16'h000f);
    acc(1'b1, 1'b1, 16'h000c);
    acc(1'b1, 1'b0, 16'h00f6);
    acc(1'b0, 1'b0, 16'h0000);
    chk("R9 and clear", rdata, 16'h000c);
    @(negedge clk);
    we = 1'b1; dc = 1'b1; wdata = 16'h0000; strobe = 1'b1; gpio_evt = 8'h01;
    @(negedge clk);
    strobe = 1'b0; gpio_evt = 8'h00;
    acc(1'b1, 1'b0, 16'h00f6);
    acc(1'b0, 1'b0, 16'h0000);
    chk("R9 event beats clear", rdata, 16'h0001);

    finish_run();
  end
endmodule